// File: doc/BRIEF.md
# Ping-Pong Storage Bank Manager

This block steers a stream of frame words into one of two storage banks that take turns. The bank in use is the only one with power. When the last word that fills it is accepted, the block powers the other, empty bank. It then holds the input back while that bank settles and makes it the target. The bank that just filled keeps its data and loses its power. Each bank keeps a count of the words it holds. Once either bank holds a programmable number of complete blocks, the next acquisition start raises a request to power up a bulk-storage stage further downstream.

A retrieval request from the host empties both banks. Incoming frames are held back with backpressure. Bank 0 and then bank 1 are powered one at a time and switched to the high-speed read mode. After a settle delay, one block at a time is handed downstream through a valid/ready handshake. When both banks are empty, writing resumes into bank 0. The bank write and command protocols are outside this block: it issues the bank select, the power enables and the speed-mode selects, and it counts the transfers.

Top module: `pingpong_bank_mgr`

## Requirements
- R1: A word accepted on `in_valid && in_ready` while the active bank has room appears on `wr_valid`/`wr_data` one cycle later, with `wr_bank` equal to the active bank.
- R2: While input is being accepted, only the active bank has power: `bank_pwr` is 2'b01 for bank 0 and 2'b10 for bank 1. During a drain, only the bank being drained has power.
- R3: If the accepted word fills the active bank and the other bank is empty, `bank_pwr` becomes 2'b11 on the next cycle. `in_ready` then stays low for `cfg_settle`+1 cycles, after which `active_bank` flips and only the new bank keeps power.
- R4: `bulk_pwr_req` rises one cycle after an `acq_start` pulse if either bank holds at least `cfg_thresh_blocks` complete blocks (`cfg_thresh_blocks` of 0 disables this). It stays high until a drain completes, and it is also high for the whole drain.
- R5: `bank_hs` is 0 (default-speed write mode) except during a drain, when only the bit of the bank being drained is set.
- R6: After a `host_retrieve` pulse, `in_ready` is low from the next cycle until the drain ends. Bank 0 is drained before bank 1. Each bank gives ceil(words/BLOCK_WORDS) accepted `drain_valid && drain_ready` beats, each tagged with `drain_bank`.
- R7: After a drain, both banks are empty, `active_bank` is 0, `bank_pwr` is 2'b01, `bank_hs` is 0, `bulk_pwr_req` is low and new words are written to bank 0.
- R8: A word accepted while the active bank is full and the other bank is not empty is dropped: no `wr_valid` follows. `overflow_flag` then stays set until reset.
- R9: A `host_retrieve` while both banks are empty starts no drain. `drain_valid` stays low, and `in_ready` returns after one cycle.
- R10: After reset, `in_ready` is 1, `bank_pwr` is 2'b01, `bank_hs`, `active_bank`, `wr_valid`, `bulk_pwr_req`, `drain_valid` and `overflow_flag` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_thresh_blocks | input | THR_W | Wake threshold in complete blocks, 0 disables |
| cfg_settle | input | SETTLE_W | Extra settle cycles after a bank is powered |
| acq_start | input | 1 | Pulse at the start of an acquisition |
| host_retrieve | input | 1 | Pulse requesting a full drain |
| in_valid | input | 1 | Frame word valid |
| in_data | input | DATA_W | Frame word |
| in_ready | output | 1 | Block accepts a word |
| wr_valid | output | 1 | Word to be written into a bank |
| wr_bank | output | 1 | Target bank of the write |
| wr_data | output | DATA_W | Word to be written |
| bank_pwr | output | 2 | Power enable per bank |
| bank_hs | output | 2 | High-speed mode select per bank |
| drain_valid | output | 1 | One block ready to move downstream |
| drain_bank | output | 1 | Bank the block comes from |
| drain_ready | input | 1 | Downstream takes the block |
| drain_active | output | 1 | Drain in progress |
| bulk_pwr_req | output | 1 | Power request for the bulk-storage stage |
| active_bank | output | 1 | Bank currently taking writes |
| overflow_flag | output | 1 | Sticky: a word was dropped |

## Verification
The bench fills bank 0 word by word with random gaps and a random settle delay. It counts the exact number of backpressure cycles at the swap, so a design that switches a cycle early or late, or that loses the word that fills the bank, shows up. It crosses the wake threshold one word at a time around an `acq_start` pulse, which catches an off-by-one in the block count. It fills both banks and sends one more word, to see that this word is dropped and not written over stored data. It runs drains with a random `drain_ready`, one with two full banks and one with a partial block. These catch a wrong bank order, a partial block that is never drained, input accepted during the drain, and a manager that does not return to bank 0.

// File: rtl/ppb_pkg.sv
package ppb_pkg;

  typedef enum logic [1:0] {
    ST_RUN     = 2'd0,
    ST_SWAP    = 2'd1,
    ST_DR_WAKE = 2'd2,
    ST_DR_XFER = 2'd3
  } ppb_state_e;

  function automatic logic [1:0] bank_onehot(input logic b);
    return b ? 2'b10 : 2'b01;
  endfunction

endpackage

// File: rtl/ppb_fill_ctr.sv
module ppb_fill_ctr #(
  parameter int BLOCK_WORDS = 128,
  parameter int BANK_WORDS  = 1024,
  parameter int FILL_W      = 11,
  parameter int BLKS_W      = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              inc,
  input  logic              dec_blk,
  output logic [BLKS_W-1:0] blocks,
  output logic              empty,
  output logic              full,
  output logic              almost_full,
  output logic              last_blk
);
  localparam int BLK_SH = $clog2(BLOCK_WORDS);

  logic [FILL_W-1:0] words;

  assign blocks      = words[FILL_W-1:BLK_SH];
  assign empty       = (words == '0);
  assign full        = (words == FILL_W'(BANK_WORDS));
  assign almost_full = (words == FILL_W'(BANK_WORDS - 1));
  assign last_blk    = (words <= FILL_W'(BLOCK_WORDS));

  always_ff @(posedge clk) begin
    if (rst) begin
      words <= '0;
    end else if (inc) begin
      words <= words + 1'b1;
    end else if (dec_blk) begin
      words <= last_blk ? '0 : words - FILL_W'(BLOCK_WORDS);
    end
  end
endmodule

// File: rtl/ppb_settle_timer.sv
module ppb_settle_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] val,
  output logic         done
);
  logic [W-1:0] cnt;

  assign done = (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= val;
    end else if (!done) begin
      cnt <= cnt - 1'b1;
    end
  end
endmodule

// File: rtl/ppb_thresh_wake.sv
module ppb_thresh_wake #(
  parameter int BLKS_W = 4,
  parameter int THR_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [BLKS_W-1:0] blocks0,
  input  logic [BLKS_W-1:0] blocks1,
  input  logic [THR_W-1:0]  thresh,
  input  logic              acq_start,
  input  logic              clr,
  output logic              wake
);
  logic hit;

  assign hit = (thresh != '0) &&
               ((32'(blocks0) >= 32'(thresh)) || (32'(blocks1) >= 32'(thresh)));

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      wake <= 1'b0;
    end else if (acq_start && hit) begin
      wake <= 1'b1;
    end
  end
endmodule

// File: rtl/pingpong_bank_mgr.sv
module pingpong_bank_mgr
  import ppb_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int BLOCK_WORDS = 128,
  parameter int BANK_BLOCKS = 8,
  parameter int THR_W       = 8,
  parameter int SETTLE_W    = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [THR_W-1:0]    cfg_thresh_blocks,
  input  logic [SETTLE_W-1:0] cfg_settle,
  input  logic                acq_start,
  input  logic                host_retrieve,
  input  logic                in_valid,
  input  logic [DATA_W-1:0]   in_data,
  output logic                in_ready,
  output logic                wr_valid,
  output logic                wr_bank,
  output logic [DATA_W-1:0]   wr_data,
  output logic [1:0]          bank_pwr,
  output logic [1:0]          bank_hs,
  output logic                drain_valid,
  output logic                drain_bank,
  input  logic                drain_ready,
  output logic                drain_active,
  output logic                bulk_pwr_req,
  output logic                active_bank,
  output logic                overflow_flag
);
  localparam int BANK_WORDS = BLOCK_WORDS * BANK_BLOCKS;
  localparam int FILL_W     = $clog2(BANK_WORDS + 1);
  localparam int BLK_SH     = $clog2(BLOCK_WORDS);
  localparam int BLKS_W     = FILL_W - BLK_SH;

  ppb_state_e state;
  logic       act;
  logic       dr_bank;
  logic       pend;
  logic [1:0] pwr_q;
  logic [1:0] hs_q;
  logic       ovf_q;

  logic [1:0] empty, full, afull, last;
  logic [1:0] inc, dec;
  logic [BLKS_W-1:0] blks [2];

  logic acc, wr_ok, drain_fire, other;
  logic go_drain, go_swap, next_bank, drain_done, tmr_load, tmr_done;

  assign other      = ~act;
  assign in_ready   = (state == ST_RUN) && !pend;
  assign acc        = in_valid && in_ready;
  assign wr_ok      = acc && !full[act];
  assign drain_fire = (state == ST_DR_XFER) && drain_ready;

  assign go_drain   = (state == ST_RUN) && pend && !(empty[0] && empty[1]);
  assign go_swap    = (state == ST_RUN) && !pend && wr_ok && afull[act] && empty[other];
  assign next_bank  = drain_fire && last[dr_bank] && !empty[~dr_bank];
  assign drain_done = drain_fire && last[dr_bank] && empty[~dr_bank];
  assign tmr_load   = go_drain || go_swap || next_bank;

  generate
    for (genvar b = 0; b < 2; b++) begin : g_bank
      assign inc[b] = wr_ok && (act == 1'(b));
      assign dec[b] = drain_fire && (dr_bank == 1'(b));

      ppb_fill_ctr #(
        .BLOCK_WORDS(BLOCK_WORDS),
        .BANK_WORDS (BANK_WORDS),
        .FILL_W     (FILL_W),
        .BLKS_W     (BLKS_W)
      ) u_fill (
        .clk        (clk),
        .rst        (rst),
        .inc        (inc[b]),
        .dec_blk    (dec[b]),
        .blocks     (blks[b]),
        .empty      (empty[b]),
        .full       (full[b]),
        .almost_full(afull[b]),
        .last_blk   (last[b])
      );
    end
  endgenerate

  ppb_settle_timer #(.W(SETTLE_W)) u_settle (
    .clk (clk),
    .rst (rst),
    .load(tmr_load),
    .val (cfg_settle),
    .done(tmr_done)
  );

  ppb_thresh_wake #(.BLKS_W(BLKS_W), .THR_W(THR_W)) u_wake (
    .clk      (clk),
    .rst      (rst),
    .blocks0  (blks[0]),
    .blocks1  (blks[1]),
    .thresh   (cfg_thresh_blocks),
    .acq_start(acq_start),
    .clr      (drain_done),
    .wake     (bulk_pwr_req_wake)
  );

  logic bulk_pwr_req_wake;

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_RUN;
      act      <= 1'b0;
      dr_bank  <= 1'b0;
      pend     <= 1'b0;
      pwr_q    <= 2'b01;
      hs_q     <= 2'b00;
      ovf_q    <= 1'b0;
      wr_valid <= 1'b0;
      wr_bank  <= 1'b0;
      wr_data  <= '0;
    end else begin
      wr_valid <= wr_ok;
      if (wr_ok) begin
        wr_bank <= act;
        wr_data <= in_data;
      end
      if (acc && full[act]) ovf_q <= 1'b1;
      if (host_retrieve) pend <= 1'b1;

      unique case (state)
        ST_RUN: begin
          if (pend) begin
            pend <= host_retrieve;
            if (go_drain) begin
              state   <= ST_DR_WAKE;
              dr_bank <= empty[0];
              pwr_q   <= bank_onehot(empty[0]);
              hs_q    <= bank_onehot(empty[0]);
            end
          end else if (go_swap) begin
            state <= ST_SWAP;
            pwr_q <= 2'b11;
          end
        end
        ST_SWAP: begin
          if (tmr_done) begin
            state <= ST_RUN;
            act   <= other;
            pwr_q <= bank_onehot(other);
          end
        end
        ST_DR_WAKE: begin
          if (tmr_done) state <= ST_DR_XFER;
        end
        ST_DR_XFER: begin
          if (next_bank) begin
            state   <= ST_DR_WAKE;
            dr_bank <= ~dr_bank;
            pwr_q   <= bank_onehot(~dr_bank);
            hs_q    <= bank_onehot(~dr_bank);
          end else if (drain_done) begin
            state <= ST_RUN;
            act   <= 1'b0;
            pwr_q <= 2'b01;
            hs_q  <= 2'b00;
          end
        end
        default: state <= ST_RUN;
      endcase
    end
  end

  assign bank_pwr      = pwr_q;
  assign bank_hs       = hs_q;
  assign drain_valid   = (state == ST_DR_XFER);
  assign drain_bank    = dr_bank;
  assign drain_active  = (state == ST_DR_WAKE) || (state == ST_DR_XFER);
  assign bulk_pwr_req  = bulk_pwr_req_wake || drain_active;
  assign active_bank   = act;
  assign overflow_flag = ovf_q;

endmodule

// File: rtl/pingpong_bank_mgr_chk.sv
module pingpong_bank_mgr_chk (
  input logic       clk,
  input logic       rst,
  input logic       in_ready,
  input logic       wr_valid,
  input logic       wr_bank,
  input logic [1:0] bank_pwr,
  input logic [1:0] bank_hs,
  input logic       drain_valid,
  input logic       drain_bank,
  input logic       drain_active,
  input logic       bulk_pwr_req,
  input logic       acq_start,
  input logic       active_bank,
  input logic       overflow_flag
);
  // R1: a write always targets a powered bank
  a_r1_write_powered: assert property (@(posedge clk) disable iff (rst)
    wr_valid |-> bank_pwr[wr_bank]);

  // R2: while taking input only the active bank is powered
  a_r2_single_power: assert property (@(posedge clk) disable iff (rst)
    in_ready |-> (bank_pwr == (active_bank ? 2'b10 : 2'b01)));

  // R4: the bulk request only rises after an acquisition start or with a drain
  a_r4_wake_cause: assert property (@(posedge clk) disable iff (rst)
    $rose(bulk_pwr_req) |-> ($past(acq_start) || drain_active));

  // R5: high-speed mode only during a drain
  a_r5_hs_in_drain: assert property (@(posedge clk) disable iff (rst)
    (bank_hs != 2'b00) |-> drain_active);

  // R5: the drained bank is powered and in high-speed mode
  a_r5_drain_mode: assert property (@(posedge clk) disable iff (rst)
    drain_valid |-> (bank_hs[drain_bank] && bank_pwr[drain_bank] && $onehot(bank_pwr)));

  // R6: no input is taken while draining
  a_r6_hold_input: assert property (@(posedge clk) disable iff (rst)
    drain_active |-> !in_ready);

  // R8: the overflow flag is sticky
  a_r8_sticky_ovf: assert property (@(posedge clk) disable iff (rst)
    overflow_flag |=> overflow_flag);
endmodule

bind pingpong_bank_mgr pingpong_bank_mgr_chk u_chk (
  .clk          (clk),
  .rst          (rst),
  .in_ready     (in_ready),
  .wr_valid     (wr_valid),
  .wr_bank      (wr_bank),
  .bank_pwr     (bank_pwr),
  .bank_hs      (bank_hs),
  .drain_valid  (drain_valid),
  .drain_bank   (drain_bank),
  .drain_active (drain_active),
  .bulk_pwr_req (bulk_pwr_req),
  .acq_start    (acq_start),
  .active_bank  (active_bank),
  .overflow_flag(overflow_flag)
);

// File: tb/pingpong_bank_mgr_tb.sv
module pingpong_bank_mgr_tb;
  localparam int DW  = 16;
  localparam int BW  = 4;
  localparam int BB  = 4;
  localparam int TW  = 4;
  localparam int SW  = 4;
  localparam int CAP = BW * BB;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [TW-1:0] cfg_thresh_blocks = '0;
  logic [SW-1:0] cfg_settle = '0;
  logic          acq_start = 1'b0;
  logic          host_retrieve = 1'b0;
  logic          in_valid = 1'b0;
  logic [DW-1:0] in_data = '0;
  logic          in_ready;
  logic          wr_valid;
  logic          wr_bank;
  logic [DW-1:0] wr_data;
  logic [1:0]    bank_pwr;
  logic [1:0]    bank_hs;
  logic          drain_valid;
  logic          drain_bank;
  logic          drain_ready = 1'b0;
  logic          drain_active;
  logic          bulk_pwr_req;
  logic          active_bank;
  logic          overflow_flag;

  int n_chk  = 0;
  int n_fail = 0;
  int cyc    = 0;

  pingpong_bank_mgr #(
    .DATA_W(DW), .BLOCK_WORDS(BW), .BANK_BLOCKS(BB), .THR_W(TW), .SETTLE_W(SW)
  ) u_dut (
    .clk(clk), .rst(rst), .cfg_thresh_blocks(cfg_thresh_blocks), .cfg_settle(cfg_settle),
    .acq_start(acq_start), .host_retrieve(host_retrieve), .in_valid(in_valid),
    .in_data(in_data), .in_ready(in_ready), .wr_valid(wr_valid), .wr_bank(wr_bank),
    .wr_data(wr_data), .bank_pwr(bank_pwr), .bank_hs(bank_hs), .drain_valid(drain_valid),
    .drain_bank(drain_bank), .drain_ready(drain_ready), .drain_active(drain_active),
    .bulk_pwr_req(bulk_pwr_req), .active_bank(active_bank), .overflow_flag(overflow_flag)
  );

  always #5 clk = ~clk;

  function automatic logic [1:0] onehot(input logic b);
    return b ? 2'b10 : 2'b01;
  endfunction

  function automatic int ceil_blocks(input int words);
    return (words + BW - 1) / BW;
  endfunction

  task automatic check(input string req, input longint got, input longint exp);
    n_chk++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got %0d expected %0d", cyc, 100000);
      finish_run();
    end
  end

  // starts and ends at a negedge
  task automatic put_word(input string req, input logic [DW-1:0] d,
                          input bit store, input logic exp_bank);
    repeat ($urandom_range(0, 2)) @(negedge clk);
    in_valid = 1'b1;
    in_data  = d;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    check({req, " wr_valid"}, wr_valid, store);
    if (store) begin
      check({req, " wr_bank"}, wr_bank, exp_bank);
      check({req, " wr_data"}, wr_data, d);
    end
  endtask

  task automatic pulse_acq();
    acq_start = 1'b1;
    @(negedge clk);
    acq_start = 1'b0;
  endtask

  task automatic run_drain(input int exp0, input int exp1);
    int  beats0 = 0;
    int  beats1 = 0;
    int  ready_hi = 0;
    int  order_bad = 0;
    int  mode_bad = 0;
    bit  started = 1'b0;
    host_retrieve = 1'b1;
    @(negedge clk);
    host_retrieve = 1'b0;
    for (int i = 0; i < 5000; i++) begin
      if (drain_active) started = 1'b1;
      if (started && !drain_active) break;
      if (in_ready) ready_hi++;
      if (drain_active && !bulk_pwr_req) mode_bad++;
      drain_ready = 1'($urandom_range(0, 1));
      if (drain_valid) begin
        if (bank_hs != onehot(drain_bank) || bank_pwr != onehot(drain_bank)) mode_bad++;
        if (drain_ready) begin
          if (drain_bank) beats1++;
          else begin
            beats0++;
            if (beats1 != 0) order_bad++;
          end
        end
      end
      @(negedge clk);
    end
    drain_ready = 1'b0;
    check("R6 input held during drain", ready_hi, 0);
    check("R6 bank0 before bank1", order_bad, 0);
    check("R6 bank0 beats", beats0, exp0);
    check("R6 bank1 beats", beats1, exp1);
    check("R5 R2 drain mode and power", mode_bad, 0);
    check("R7 active bank 0", active_bank, 0);
    check("R7 power bank0 only", bank_pwr, 2'b01);
    check("R7 hs off", bank_hs, 2'b00);
    check("R7 bulk request low", bulk_pwr_req, 0);
    check("R7 in_ready back", in_ready, 1);
  endtask

  initial begin
    int settle;
    int lows;
    void'($urandom(32'h5EED_0042));
    settle = $urandom_range(0, 5);
    cfg_settle = SW'(settle);
    cfg_thresh_blocks = TW'(2);

    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10 reset state
    check("R10 in_ready", in_ready, 1);
    check("R10 bank_pwr", bank_pwr, 2'b01);
    check("R10 bank_hs", bank_hs, 0);
    check("R10 active_bank", active_bank, 0);
    check("R10 wr_valid", wr_valid, 0);
    check("R10 bulk_pwr_req", bulk_pwr_req, 0);
    check("R10 drain_valid", drain_valid, 0);
    check("R10 overflow", overflow_flag, 0);

    // R1 R4: seven words = one complete block, below threshold
    for (int i = 0; i < 7; i++) put_word("R1 bank0", DW'($urandom), 1'b1, 1'b0);
    pulse_acq();
    check("R4 below threshold", bulk_pwr_req, 0);
    put_word("R1 bank0", DW'($urandom), 1'b1, 1'b0);
    check("R2 bank0 only", bank_pwr, 2'b01);
    pulse_acq();
    check("R4 threshold reached", bulk_pwr_req, 1);

    // R3: fill the rest of bank 0 and watch the swap
    for (int i = 8; i < CAP; i++) put_word("R1 bank0 fill", DW'($urandom), 1'b1, 1'b0);
    check("R3 both powered", bank_pwr, 2'b11);
    lows = 0;
    while (!in_ready && lows < 100) begin
      lows++;
      @(negedge clk);
    end
    check("R3 settle cycles", lows, settle + 1);
    check("R3 active flips", active_bank, 1);
    check("R3 old bank off", bank_pwr, 2'b10);
    check("R4 request held", bulk_pwr_req, 1);

    // R8: fill bank 1, then one word too many
    for (int i = 0; i < CAP; i++) put_word("R1 bank1", DW'($urandom), 1'b1, 1'b1);
    check("R8 no swap when other full", in_ready, 1);
    check("R8 no overflow yet", overflow_flag, 0);
    put_word("R8 dropped word", DW'($urandom), 1'b0, 1'b0);
    check("R8 overflow set", overflow_flag, 1);

    // R6 R7: full drain of two full banks
    run_drain(BB, BB);
    check("R8 overflow sticky", overflow_flag, 1);

    // R7: writes go to bank 0 again; partial block drained
    for (int i = 0; i < 6; i++) put_word("R7 bank0 after drain", DW'($urandom), 1'b1, 1'b0);
    run_drain(ceil_blocks(6), 0);

    // R9: retrieve with nothing stored
    begin
      int dv = 0;
      int pw = 0;
      host_retrieve = 1'b1;
      @(negedge clk);
      host_retrieve = 1'b0;
      check("R9 one cycle hold", in_ready, 0);
      for (int i = 0; i < 8; i++) begin
        @(negedge clk);
        if (drain_valid || drain_active) dv++;
        if (bank_pwr != 2'b01) pw++;
      end
      check("R9 no drain", dv, 0);
      check("R9 power unchanged", pw, 0);
      check("R9 in_ready back", in_ready, 1);
    end

    // R4: threshold 0 disables the wake
    cfg_thresh_blocks = '0;
    for (int i = 0; i < 8; i++) put_word("R1 bank0", DW'($urandom), 1'b1, 1'b0);
    pulse_acq();
    check("R4 zero threshold disabled", bulk_pwr_req, 0);

    finish_run();
  end
endmodule